// File: doc/BRIEF.md
# Windowed NAND Page Parity Engine

This block sits beside a 32-bit memory data path and watches every word that passes it. When an access falls inside a programmable address window and the engine is enabled, the four bytes of the word are folded into a running Hamming-style parity. The parity has six column bits and sixteen line bits and follows the SSFDC scheme. The data is split into 256-byte blocks. When the last word of a block arrives, the 22-bit result is pushed into a bank of eight result slots. Older results move one slot up, so slot 0 always holds the newest block.

Software sets the window with a base address and a 10-bit word mask, then turns on the engine. It lets a NAND page stream through the memory path, and then reads back the parity of each 256-byte block to store in spare area or compare later. A status count in the control register tells software how many slots hold valid results. Writing any value to the clear register discards all results, the count, and any partly accumulated block.

Top module: `pg_ecc_top`

## Requirements
- R1: After reset, every readable register returns zero. This covers control (enable 0, count 0), base, mask and all eight result slots.
- R2: While the enable bit (control bit 0) is 0, accesses that hit the window change neither the result slots, the count, nor the partial block state.
- R3: An access hits when its address equals the stored base in every bit outside the ignored set. The ignored set is address bits [1:0] plus the mask value shifted left by 2. With a contiguous mask M, the window is 4·(M+1) bytes starting at base & ~(M<<2). Accesses that miss are ignored.
- R4: Every 64 hitting, enabled word accesses complete one 256-byte block. A word from the w-th such access supplies the bytes at block indices 4w..4w+3, taking data bits [7:0] first (little-endian). The result is readable at slot 0 in the cycle after the 64th access.
- R5: Result bits [21:16] are column parity, taken over the XOR of all 256 bytes. Bit 16+2j is the XOR of data bit positions whose bit j is 0, and bit 17+2j is the XOR of positions whose bit j is 1, for j = 0, 1, 2. No final inversion is applied.
- R6: Result bits [15:0] are line parity. For each bit k of the 8-bit byte index, bit 2k is the XOR of the parities of bytes whose index bit k is 0, and bit 2k+1 covers bytes whose index bit k is 1.
- R7: On each block completion, slot x+1 takes the old value of slot x for x = 0..6, slot 0 takes the new result, and the old value of slot 7 is lost.
- R8: Control bits [3:1] report the number of completed blocks since reset or clear. The count saturates at 7, and writes to these bits have no effect.
- R9: A write of any data to the clear register zeroes all slots and the count and discards the partial block. An access in the same cycle as that write is discarded as well.
- R10: The register map uses byte offsets. Control is at 0x00, base at 0x04 (reads back with bits [1:0] zero), mask at 0x08 (10 bits, upper bits read zero), clear at 0x0C (reads zero), and result slot x at 0x10+4x (bits [31:22] read zero). Register reads are combinational. Writes take effect at the next clock edge. Offsets with bits [1:0] non-zero are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mon_valid | input | 1 | A word access is present on the watched path this cycle |
| mon_addr | input | 32 | Byte address of the watched access |
| mon_data | input | 32 | Data of the watched access (read or write) |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 6 | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for reg_addr |

## Verification
Errors in the word counter only show at the block boundary. A miscounted or stray step moves the moment the count field advances by one or more accesses, so the bench reads the count after the 63rd and after the 64th word. Wrong parity folding or a wrong byte index shows up in slot 0 in the cycle after the 64th word. Shift faults appear as stale or duplicated values across slots only after several blocks, so the bench keeps a full history of nine blocks and compares all eight slots. A clear that misses the partial state shows up one block later, as a result that differs from a fresh block's parity.

// File: rtl/pg_ecc_pkg.sv
package pg_ecc_pkg;
   localparam int unsigned COL_W = 6;
   localparam int unsigned LANES = 4;

   // register word indices (byte offset >> 2)
   localparam int unsigned WI_CTRL = 0;
   localparam int unsigned WI_BASE = 1;
   localparam int unsigned WI_MASK = 2;
   localparam int unsigned WI_CLR  = 3;
   localparam int unsigned WI_RES0 = 4;

   // column parity contribution of a single byte
   function automatic logic [COL_W-1:0] byte_col(input logic [7:0] b);
      logic [COL_W-1:0] c;
      c = '0;
      for (int q = 0; q < 8; q++) begin
         if (b[q]) begin
            for (int j = 0; j < 3; j++) begin
               c[2*j + ((q >> j) & 1)] = ~c[2*j + ((q >> j) & 1)];
            end
         end
      end
      return c;
   endfunction
endpackage

// File: rtl/pg_ecc_win.sv
module pg_ecc_win #(
   parameter int unsigned ADDR_W = 32,
   parameter int unsigned MASK_W = 10
) (
   input  logic [ADDR_W-1:0] addr,
   input  logic [ADDR_W-1:0] base,
   input  logic [MASK_W-1:0] mask,
   output logic              hit
);
   localparam int unsigned PAD_W = ADDR_W - MASK_W - 2;

   generate
      if (MASK_W + 3 > ADDR_W) begin : g_bad_width
         $error("pg_ecc_win: MASK_W too wide for ADDR_W");
      end
   endgenerate

   logic [ADDR_W-1:0] ignore;

   always_comb begin
      ignore = {{PAD_W{1'b0}}, mask, 2'b11};
      hit    = ((addr ^ base) & ~ignore) == '0;
   end
endmodule

// File: rtl/pg_ecc_accum.sv
module pg_ecc_accum
   import pg_ecc_pkg::*;
#(
   parameter int unsigned IDX_W = 8,
   parameter int unsigned RES_W = COL_W + 2*IDX_W
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr,
   input  logic             step,
   input  logic [31:0]      data,
   output logic             done,
   output logic [RES_W-1:0] res
);
   localparam int unsigned WC_W   = IDX_W - 2;
   localparam int unsigned LINE_W = 2*IDX_W;

   generate
      if (IDX_W < 3) begin : g_bad_idx
         $error("pg_ecc_accum: block must hold at least two words");
      end
      if (RES_W != COL_W + LINE_W) begin : g_bad_res
         $error("pg_ecc_accum: RES_W inconsistent with IDX_W");
      end
   endgenerate

   logic [WC_W-1:0]   wcnt_q;
   logic [COL_W-1:0]  col_q,  col_w;
   logic [LINE_W-1:0] line_q, line_w;

   // contribution of the present word, byte lanes in little-endian order
   always_comb begin
      logic [7:0]       b;
      logic [IDX_W-1:0] idx;
      logic             p;
      col_w  = '0;
      line_w = '0;
      for (int j = 0; j < LANES; j++) begin
         b     = data[8*j +: 8];
         p     = ^b;
         idx   = {wcnt_q, 2'(j)};
         col_w = col_w ^ byte_col(b);
         for (int k = 0; k < IDX_W; k++) begin
            line_w[2*k + idx[k]] = line_w[2*k + idx[k]] ^ p;
         end
      end
   end

   assign done = step && (wcnt_q == '1);
   assign res  = {col_q ^ col_w, line_q ^ line_w};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wcnt_q <= '0;
         col_q  <= '0;
         line_q <= '0;
      end else if (clr) begin
         wcnt_q <= '0;
         col_q  <= '0;
         line_q <= '0;
      end else if (step) begin
         wcnt_q <= wcnt_q + 1'b1;
         if (done) begin
            col_q  <= '0;
            line_q <= '0;
         end else begin
            col_q  <= col_q ^ col_w;
            line_q <= line_q ^ line_w;
         end
      end
   end
endmodule

// File: rtl/pg_ecc_bank.sv
module pg_ecc_bank #(
   parameter int unsigned DEPTH = 8,
   parameter int unsigned RES_W = 22
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic                        clr,
   input  logic                        push,
   input  logic [RES_W-1:0]            din,
   output logic [DEPTH-1:0][RES_W-1:0] slots
);
   generate
      if (DEPTH < 2) begin : g_bad_depth
         $error("pg_ecc_bank: DEPTH must be at least 2");
      end
      for (genvar i = 0; i < DEPTH; i++) begin : g_slot
         logic [RES_W-1:0] nxt;
         if (i == 0) begin : g_head
            assign nxt = din;
         end else begin : g_tail
            assign nxt = slots[i-1];
         end
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)      slots[i] <= '0;
            else if (clr)    slots[i] <= '0;
            else if (push)   slots[i] <= nxt;
         end
      end
   endgenerate
endmodule

// File: rtl/pg_ecc_top.sv
module pg_ecc_top
   import pg_ecc_pkg::*;
#(
   parameter int unsigned ADDR_W    = 32,
   parameter int unsigned MASK_W    = 10,
   parameter int unsigned NUM_RES   = 8,
   parameter int unsigned BLK_BYTES = 256,
   parameter int unsigned RA_W      = 6
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              mon_valid,
   input  logic [ADDR_W-1:0] mon_addr,
   input  logic [31:0]       mon_data,
   input  logic              reg_wr,
   input  logic [RA_W-1:0]   reg_addr,
   input  logic [31:0]       reg_wdata,
   output logic [31:0]       reg_rdata
);
   localparam int unsigned IDX_W = $clog2(BLK_BYTES);
   localparam int unsigned RES_W = COL_W + 2*IDX_W;
   localparam int unsigned CNT_W = $clog2(NUM_RES);
   localparam int unsigned WI_W  = RA_W - 2;
   localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(NUM_RES - 1);

   generate
      if (ADDR_W > 32) begin : g_bad_addr
         $error("pg_ecc_top: ADDR_W above register width");
      end
      if ((1 << IDX_W) != BLK_BYTES) begin : g_bad_blk
         $error("pg_ecc_top: BLK_BYTES must be a power of two");
      end
      if ((1 << CNT_W) != NUM_RES) begin : g_bad_num
         $error("pg_ecc_top: NUM_RES must be a power of two");
      end
      if (RES_W > 32 || CNT_W + 1 > 32) begin : g_bad_res
         $error("pg_ecc_top: result does not fit a register");
      end
      if ((1 << WI_W) < WI_RES0 + NUM_RES) begin : g_bad_ra
         $error("pg_ecc_top: RA_W too small for the register map");
      end
   endgenerate

   logic                       en_q;
   logic [CNT_W-1:0]           cnt_q;
   logic [ADDR_W-1:2]          base_q;
   logic [MASK_W-1:0]          mask_q;
   logic [WI_W-1:0]            widx;
   logic                       aligned;
   logic                       clr_hit;
   logic                       win_hit;
   logic                       acc_step;
   logic                       blk_push;
   logic [RES_W-1:0]           blk_res;
   logic [NUM_RES-1:0][RES_W-1:0] bank_res;
   logic [CNT_W-1:0]           resx;

   assign widx     = reg_addr[RA_W-1:2];
   assign aligned  = reg_addr[1:0] == 2'b00;
   assign clr_hit  = reg_wr && aligned && (widx == WI_W'(WI_CLR));
   assign acc_step = mon_valid && win_hit && en_q && !clr_hit;
   assign resx     = CNT_W'(widx - WI_W'(WI_RES0));

   pg_ecc_win #(.ADDR_W(ADDR_W), .MASK_W(MASK_W)) u_win (
      .addr (mon_addr),
      .base ({base_q, 2'b00}),
      .mask (mask_q),
      .hit  (win_hit)
   );

   pg_ecc_accum #(.IDX_W(IDX_W), .RES_W(RES_W)) u_acc (
      .clk   (clk),
      .rst_n (rst_n),
      .clr   (clr_hit),
      .step  (acc_step),
      .data  (mon_data),
      .done  (blk_push),
      .res   (blk_res)
   );

   pg_ecc_bank #(.DEPTH(NUM_RES), .RES_W(RES_W)) u_bank (
      .clk   (clk),
      .rst_n (rst_n),
      .clr   (clr_hit),
      .push  (blk_push),
      .din   (blk_res),
      .slots (bank_res)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         en_q   <= 1'b0;
         base_q <= '0;
         mask_q <= '0;
      end else if (reg_wr && aligned) begin
         if (widx == WI_W'(WI_CTRL)) en_q   <= reg_wdata[0];
         if (widx == WI_W'(WI_BASE)) base_q <= reg_wdata[ADDR_W-1:2];
         if (widx == WI_W'(WI_MASK)) mask_q <= reg_wdata[MASK_W-1:0];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                           cnt_q <= '0;
      else if (clr_hit)                     cnt_q <= '0;
      else if (blk_push && cnt_q != CNT_MAX) cnt_q <= cnt_q + 1'b1;
   end

   always_comb begin
      reg_rdata = '0;
      if (aligned) begin
         if (widx == WI_W'(WI_CTRL))      reg_rdata[CNT_W:0]     = {cnt_q, en_q};
         else if (widx == WI_W'(WI_BASE)) reg_rdata[ADDR_W-1:0] = {base_q, 2'b00};
         else if (widx == WI_W'(WI_MASK)) reg_rdata[MASK_W-1:0] = mask_q;
         else if (widx >= WI_W'(WI_RES0) && widx < WI_W'(WI_RES0 + NUM_RES))
            reg_rdata[RES_W-1:0] = bank_res[resx];
      end
   end

   // R3: a block can only complete on an enabled access inside the window
   p_push_only_hit_r3: assert property (@(posedge clk) disable iff (!rst_n)
      blk_push |-> (mon_valid && win_hit && en_q));

   // R2: with the engine off the result bank does not move
   p_disabled_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (!en_q && !clr_hit) |=> $stable(bank_res));

   // R7: the previous newest result moves into slot 1
   p_push_moves_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (blk_push && !clr_hit) |=> (bank_res[1] == $past(bank_res[0])));

   // R8: zero completed blocks means an empty bank
   p_cnt_empty_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (cnt_q == '0) |-> (bank_res == '0));

   // R8: the count holds once saturated
   p_cnt_sat_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (cnt_q == CNT_MAX && !clr_hit) |=> (cnt_q == CNT_MAX));

   // R9: a clear write empties the bank and the count
   p_clear_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
      clr_hit |=> (cnt_q == '0 && bank_res == '0));
endmodule

// File: tb/pg_ecc_top_tb.sv
`timescale 1ns/1ps
module pg_ecc_top_tb;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        mon_valid = 1'b0;
   logic [31:0] mon_addr = '0;
   logic [31:0] mon_data = '0;
   logic        reg_wr = 1'b0;
   logic [5:0]  reg_addr = '0;
   logic [31:0] reg_wdata = '0;
   logic [31:0] reg_rdata;

   int n_cmp = 0;
   int n_err = 0;
   bit finished = 1'b0;

   always #5 clk = ~clk;

   pg_ecc_top u_dut (
      .clk(clk), .rst_n(rst_n), .mon_valid(mon_valid), .mon_addr(mon_addr),
      .mon_data(mon_data), .reg_wr(reg_wr), .reg_addr(reg_addr),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata)
   );

   typedef struct packed {
      logic [31:0] base;
      logic [9:0]  mask;
      logic [31:0] addr;
      logic        hit;
   } win_vec_t;

   localparam win_vec_t WIN_TAB [10] = '{
      '{32'h2000_0000, 10'h0FF, 32'h2000_03FC, 1'b1},
      '{32'h2000_0000, 10'h0FF, 32'h2000_0400, 1'b0},
      '{32'h2000_0123, 10'h003, 32'h2000_012C, 1'b1},
      '{32'h2000_0123, 10'h003, 32'h2000_0130, 1'b0},
      '{32'h3000_0008, 10'h000, 32'h3000_000B, 1'b1},
      '{32'h3000_0008, 10'h000, 32'h3000_000C, 1'b0},
      '{32'h4000_0800, 10'h3FF, 32'h4000_0000, 1'b1},
      '{32'h4000_0800, 10'h3FF, 32'h4000_1000, 1'b0},
      '{32'h5000_0000, 10'h03F, 32'h5000_00FC, 1'b1},
      '{32'h5000_0000, 10'h03F, 32'h1000_0000, 1'b0}
   };

   localparam logic [31:0] BLK_BASE = 32'h5000_0000;

   logic [31:0] blk [64];
   logic [31:0] hist [16];
   int          n_hist = 0;

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_err++;
         $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
      end
   endtask

   task automatic rd(input logic [5:0] a, output logic [31:0] d);
      @(negedge clk);
      reg_addr = a;
      #1 d = reg_rdata;
   endtask

   task automatic wr(input logic [5:0] a, input logic [31:0] d);
      @(negedge clk);
      reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
      @(posedge clk);
      #1 reg_wr = 1'b0;
   endtask

   task automatic word(input logic [31:0] a, input logic [31:0] d);
      @(negedge clk);
      mon_valid = 1'b1; mon_addr = a; mon_data = d;
      @(posedge clk);
      #1 mon_valid = 1'b0;
   endtask

   task automatic send_words(input int first, input int last);
      for (int w = first; w <= last; w++) word(BLK_BASE + 32'(4*w), blk[w]);
   endtask

   // independent byte-serial model of the block parity
   function automatic logic [31:0] ref_ecc();
      logic [5:0]  col;
      logic [15:0] line;
      logic [7:0]  b;
      col = '0; line = '0;
      for (int i = 0; i < 256; i++) begin
         b = blk[i/4][8*(i%4) +: 8];
         for (int k = 0; k < 8; k++) begin
            if ((i >> k) & 1) line[2*k+1] ^= ^b;
            else              line[2*k]   ^= ^b;
         end
         for (int q = 0; q < 8; q++) begin
            if (b[q]) begin
               for (int j = 0; j < 3; j++) begin
                  if ((q >> j) & 1) col[2*j+1] ^= 1'b1;
                  else              col[2*j]   ^= 1'b1;
               end
            end
         end
      end
      return {10'b0, col, line};
   endfunction

   task automatic fill_prng(input logic [31:0] seed);
      logic [31:0] s;
      s = seed;
      for (int w = 0; w < 64; w++) begin
         s = s ^ (s << 13); s = s ^ (s >> 17); s = s ^ (s << 5);
         blk[w] = s;
      end
   endtask

   task automatic run_block(input string req);
      logic [31:0] d;
      logic [31:0] c0;
      rd(6'h00, c0);
      send_words(0, 62);
      rd(6'h00, d);
      chk({req, " count before 64th word"}, d, c0);
      send_words(63, 63);
      hist[n_hist] = ref_ecc();
      n_hist++;
      rd(6'h10, d);
      chk({req, " slot0 after block"}, d, hist[n_hist-1]);
   endtask

   initial begin
      #(200000 * 10);
      if (!finished) begin
         n_cmp++; n_err++;
         $display("FAIL watchdog: actual hung expected finished");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_err);
         $finish;
      end
   end

   initial begin
      logic [31:0] d;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R1: reset state of every register
      for (int a = 0; a < 12; a++) begin
         rd(6'(4*a), d);
         chk("R1 reset value", d, 32'h0);
      end

      // R3: window vectors walked from the table
      foreach (WIN_TAB[i]) begin
         wr(6'h0C, 32'h0);
         wr(6'h04, WIN_TAB[i].base);
         wr(6'h08, {22'b0, WIN_TAB[i].mask});
         wr(6'h00, 32'h1);
         word(WIN_TAB[i].addr, 32'h0000_0001);
         for (int w = 0; w < 63; w++) word(WIN_TAB[i].base, 32'h0);
         rd(6'h00, d);
         chk("R3 window hit/miss", d, WIN_TAB[i].hit ? 32'h3 : 32'h1);
      end

      // R10: readback masking
      wr(6'h04, 32'hFFFF_FFFF);
      rd(6'h04, d); chk("R10 base low bits", d, 32'hFFFF_FFFC);
      wr(6'h08, 32'hFFFF_FFFF);
      rd(6'h08, d); chk("R10 mask width", d, 32'h0000_03FF);
      rd(6'h0C, d); chk("R10 clear reads zero", d, 32'h0);

      // block window setup
      wr(6'h0C, 32'h1234_5678);
      wr(6'h04, BLK_BASE);
      wr(6'h08, 32'h3F);
      wr(6'h00, 32'h1);
      n_hist = 0;

      // R4 R6: incrementing bytes, little-endian lanes
      for (int w = 0; w < 64; w++)
         blk[w] = {8'(4*w+3), 8'(4*w+2), 8'(4*w+1), 8'(4*w)};
      run_block("R4 R6 incrementing");

      // R5 R6: a single set bit, hand-derived result
      for (int w = 0; w < 64; w++) blk[w] = 32'h0;
      blk[41] = 32'h4000_0000;   // byte index 0xA7 = 0x40
      run_block("R5 R6 single bit");
      rd(6'h10, d); chk("R5 single bit literal", d, 32'h0029_996A);
      rd(6'h14, d); chk("R7 slot1 after second block", d, hist[0]);

      // R2: engine off, the window is hit but nothing moves
      wr(6'h00, 32'h0);
      fill_prng(32'hACE1_0001);
      send_words(0, 63);
      rd(6'h00, d); chk("R2 count unchanged", d, 32'h4);
      rd(6'h10, d); chk("R2 slot0 unchanged", d, hist[1]);
      wr(6'h00, 32'h1);
      fill_prng(32'h0BAD_F00D);
      run_block("R2 R4 no partial left while off");

      // R7 R8: saturate the count and check the whole bank
      for (int b = 0; b < 6; b++) begin
         fill_prng(32'h1357_0000 + 32'(b) * 32'h9E37);
         run_block("R4 R5 R6 pseudo-random");
      end
      rd(6'h00, d); chk("R8 count saturated", d, 32'hF);
      for (int x = 0; x < 8; x++) begin
         rd(6'(16 + 4*x), d);
         chk("R7 slot history", d, hist[n_hist-1-x]);
         chk("R10 result upper bits zero", d & 32'hFFC0_0000, 32'h0);
      end
      wr(6'h00, 32'h1);
      rd(6'h00, d); chk("R8 count bits ignore writes", d, 32'hF);
      rd(6'h01, d); chk("R10 misaligned read zero", d, 32'h0);

      // R9: clear in the middle of a block
      fill_prng(32'h2468_ACE0);
      send_words(0, 9);
      wr(6'h0C, 32'hDEAD_BEEF);
      rd(6'h00, d); chk("R9 count cleared", d, 32'h1);
      for (int x = 0; x < 8; x++) begin
         rd(6'(16 + 4*x), d);
         chk("R9 slot cleared", d, 32'h0);
      end
      n_hist = 0;
      fill_prng(32'h7777_1111);
      run_block("R9 fresh block after clear");
      rd(6'h00, d); chk("R9 count one after clear", d, 32'h3);

      // R9: access coinciding with the clear write is dropped
      @(negedge clk);
      reg_wr = 1'b1; reg_addr = 6'h0C; reg_wdata = 32'h0;
      mon_valid = 1'b1; mon_addr = BLK_BASE; mon_data = 32'hFFFF_0001;
      @(posedge clk);
      #1 reg_wr = 1'b0; mon_valid = 1'b0;
      fill_prng(32'h5555_9999);
      run_block("R9 simultaneous access dropped");
      rd(6'h00, d); chk("R9 count after simultaneous clear", d, 32'h3);

      finished = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_err);
      $finish;
   end
endmodule